// File: doc/BRIEF.md
# Debug Mode Entry and Exit State Controller

This block keeps the architectural state that a hart saves when it stops in Debug Mode and restores when it leaves. A halt request carries a cause code. On the next clock edge the block records that cause and the privilege level and virtualization bit the hart was running at. It also stores the address of the instruction that should run next as the saved debug pc. The current landing-pad expectation flag is moved into a saved copy, and the live flag is forced to "no landing pad expected".

A resume comes either from a resume request or from a decoded debug-return instruction that is executed legally, meaning in Debug Mode and not from the program buffer. On the edge after a resume, the block returns the saved pc, privilege and virtualization bit to the core with a one-cycle valid pulse. It restores the landing-pad flag only when the extension is enabled at the privilege being returned to, and it clears the saved copy. It pulses clear strobes for the memory-privilege-modify bit and, when double-trap support is present, the trap-lock bit whenever the return is to a level below machine mode. The block owns the live landing-pad flag. Outside Debug Mode, instructions update it through an update port.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After synchronous reset, `halted`, `dcsr_cause`, `dcsr_v`, `dcsr_pelp`, `dpc`, `elp`, `resume_valid`, `new_pc`, `new_virt`, `clr_mprv`, `clr_mdt` and `illegal_dret` are 0, and `dcsr_prv` and `new_priv` are 3 (machine).
- R2: A `halt_req` while not halted sets `halted` on the next edge. On that same edge, `dcsr_cause` takes `halt_cause`, `dcsr_prv` takes `cur_priv`, `dcsr_v` takes `cur_virt` and `dpc` takes `next_pc`. Privilege codes are 0 user, 1 supervisor and 3 machine.
- R3: That halt edge also copies the live landing-pad flag into `dcsr_pelp` and clears `elp`. A flag value of 1 means a landing pad is expected and 0 means none.
- R4: While halted, `elp` stays 0 and `elp_upd_en` has no effect. `lpad_nop` is high whenever `halted` and `lpad_exec` are both high.
- R5: A resume is a `resume_req`, or a `dret_valid` with `in_progbuf` low, arriving while halted and without `halt_req`. On the next edge it clears `halted` and pulses `resume_valid` for one cycle. On that edge `new_pc` equals `dpc`, `new_priv` equals `dcsr_prv` and `new_virt` equals `dcsr_v`.
- R6: On a resume, `elp` takes `dcsr_pelp` if the enable bit of the target privilege is set, otherwise 0. The enable bits are `lp_en` bit 0 for user, bit 1 for supervisor and bit 2 for machine. Code 2 has no enable. `dcsr_pelp` becomes 0 in both cases.
- R7: `clr_mprv` pulses together with `resume_valid` exactly when the target privilege is not 3.
- R8: `clr_mdt` pulses together with `resume_valid` exactly when the target privilege is not 3 (double-trap support enabled by default).
- R9: A `dret_valid` while not halted, or with `in_progbuf` high, pulses `illegal_dret` on the next edge and causes no resume.
- R10: When halted, a `halt_req` blocks any resume in the same cycle and leaves `dcsr_cause`, `dcsr_prv`, `dcsr_v`, `dpc` and `dcsr_pelp` unchanged.
- R11: A `resume_req` while not halted has no effect. No `resume_valid` or clear strobe is produced.
- R12: Outside Debug Mode, `elp_upd_en` loads `elp_upd_val` into `elp` on the next edge. A same-cycle halt takes precedence: `dcsr_pelp` receives the flag value from before the update and `elp` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Single-cycle halt request |
| halt_cause | input | CAUSE_W | Cause code carried with the halt |
| resume_req | input | 1 | Single-cycle resume request |
| dret_valid | input | 1 | Decoded debug-return instruction executing |
| in_progbuf | input | 1 | Execution is from the program buffer |
| next_pc | input | XLEN | Address of the next instruction to execute |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization bit |
| elp_upd_en | input | 1 | Instruction writes the landing-pad flag |
| elp_upd_val | input | 1 | Value written to the landing-pad flag |
| lp_en | input | 3 | Landing-pad enables: bit0 U, bit1 S, bit2 M |
| lpad_exec | input | 1 | A landing-pad instruction is executing |
| halted | output | 1 | Hart is in Debug Mode |
| dcsr_cause | output | CAUSE_W | Saved halt cause |
| dcsr_prv | output | 2 | Saved privilege |
| dcsr_v | output | 1 | Saved virtualization bit |
| dcsr_pelp | output | 1 | Saved landing-pad flag |
| dpc | output | XLEN | Saved debug pc |
| elp | output | 1 | Live landing-pad flag |
| lpad_nop | output | 1 | Landing-pad instruction is to be treated as a no-op |
| resume_valid | output | 1 | One-cycle pulse: restore values are valid |
| new_pc | output | XLEN | pc to resume at |
| new_priv | output | 2 | Privilege to resume at |
| new_virt | output | 1 | Virtualization bit to resume with |
| clr_mprv | output | 1 | Strobe: clear the memory-privilege-modify bit |
| clr_mdt | output | 1 | Strobe: clear the trap-lock bit |
| illegal_dret | output | 1 | Debug-return was illegal |

## Verification
The bench targets a landing-pad update that lands in the same cycle as a halt. A design that applies the update first would save the new value, not the old one. It also returns to a mode whose landing-pad enable is off. A design that restores unconditionally would leave a stale expectation set. A debug-return from the program buffer and a halt-plus-resume collision are both driven. A wrong design would leave Debug Mode there or overwrite the saved cause. A long random phase mixes privileges, enables and request collisions, so that strobe, restore and illegal-flag decisions are checked against a reference in every cycle.

// File: rtl/dbgst_pkg.sv
package dbgst_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    localparam logic LP_NONE   = 1'b0;
    localparam logic LP_EXPECT = 1'b1;

    typedef struct packed {
        logic halt;
        logic resume;
        logic bad_dret;
    } dbg_evt_t;

    typedef struct packed {
        priv_e prv;
        logic  v;
        logic  pelp;
    } mode_snap_t;

    function automatic logic lp_enabled(input priv_e p, input logic [2:0] en);
        case (p)
            PRIV_U:  return en[0];
            PRIV_S:  return en[1];
            PRIV_M:  return en[2];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic below_machine(input priv_e p);
        return p != PRIV_M;
    endfunction

endpackage

// File: rtl/dbg_evt_decode.sv
module dbg_evt_decode
    import dbgst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     halt_req,
    input  logic     resume_req,
    input  logic     dret_valid,
    input  logic     in_progbuf,
    output dbg_evt_t evt,
    output logic     halted,
    output logic     illegal_dret
);

    logic legal_dret;

    always_comb begin
        legal_dret   = dret_valid && halted && !in_progbuf;
        evt.halt     = halt_req && !halted;
        evt.resume   = halted && !halt_req && (resume_req || legal_dret);
        evt.bad_dret = dret_valid && (!halted || in_progbuf);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halted       <= 1'b0;
            illegal_dret <= 1'b0;
        end else begin
            illegal_dret <= evt.bad_dret;
            if (evt.halt)
                halted <= 1'b1;
            else if (evt.resume)
                halted <= 1'b0;
        end
    end

    // R9: a debug-return outside Debug Mode flags illegal and does not resume
    a_r9_bad_dret: assert property (@(posedge clk) disable iff (rst)
        (dret_valid && !halted && !halt_req) |=> (illegal_dret && !halted));

    // R9: a debug-return from the program buffer never leaves Debug Mode
    a_r9_progbuf_stays: assert property (@(posedge clk) disable iff (rst)
        (halted && dret_valid && in_progbuf && !resume_req) |=> halted);

    // R10: halt wins over a simultaneous resume
    a_r10_halt_wins: assert property (@(posedge clk) disable iff (rst)
        (halted && halt_req) |=> halted);

    // R11: no resume while running
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!halted && !halt_req) |=> !halted);

endmodule

// File: rtl/dbg_csr_hold.sv
module dbg_csr_hold
    import dbgst_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 3,
    parameter bit HAS_LP  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  dbg_evt_t           evt,
    input  logic [CAUSE_W-1:0] halt_cause,
    input  priv_e              cur_priv,
    input  logic               cur_virt,
    input  logic [XLEN-1:0]    next_pc,
    input  logic               elp_now,
    output logic [CAUSE_W-1:0] cause,
    output mode_snap_t         snap,
    output logic [XLEN-1:0]    dpc
);

    logic pelp_in;

    generate
        if (HAS_LP) begin : g_pelp
            assign pelp_in = elp_now;
        end else begin : g_no_pelp
            assign pelp_in = LP_NONE;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cause     <= '0;
            snap.prv  <= PRIV_M;
            snap.v    <= 1'b0;
            snap.pelp <= LP_NONE;
            dpc       <= '0;
        end else if (evt.halt) begin
            cause     <= halt_cause;
            snap.prv  <= cur_priv;
            snap.v    <= cur_virt;
            snap.pelp <= pelp_in;
            dpc       <= next_pc;
        end else if (evt.resume) begin
            snap.pelp <= LP_NONE;
        end
    end

    // R2: halt loads the debug pc with the next pc
    a_r2_dpc_capture: assert property (@(posedge clk) disable iff (rst)
        evt.halt |=> (dpc == $past(next_pc)));

    // R6: the saved landing-pad flag is cleared after a resume
    a_r6_pelp_cleared: assert property (@(posedge clk) disable iff (rst)
        evt.resume |=> (snap.pelp == LP_NONE));

    // R10: saved fields only change on a halt
    a_r10_cause_hold: assert property (@(posedge clk) disable iff (rst)
        !evt.halt |=> ($stable(cause) && $stable(dpc) && $stable(snap.prv)));

endmodule

// File: rtl/dbg_elp_track.sv
module dbg_elp_track
    import dbgst_pkg::*;
#(
    parameter bit HAS_LP = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  dbg_evt_t   evt,
    input  logic       halted,
    input  logic       upd_en,
    input  logic       upd_val,
    input  mode_snap_t snap,
    input  logic [2:0] lp_en,
    output logic       elp
);

    generate
        if (HAS_LP) begin : g_lp
            logic elp_q;
            always_ff @(posedge clk) begin
                if (rst)
                    elp_q <= LP_NONE;
                else if (evt.halt)
                    elp_q <= LP_NONE;
                else if (evt.resume)
                    elp_q <= lp_enabled(snap.prv, lp_en) ? snap.pelp : LP_NONE;
                else if (!halted && upd_en)
                    elp_q <= upd_val;
            end
            assign elp = elp_q;
        end else begin : g_no_lp
            assign elp = LP_NONE;
        end
    endgenerate

    // R4: landing-pad flag is quiet throughout Debug Mode
    a_r4_elp_quiet: assert property (@(posedge clk) disable iff (rst)
        halted |-> (elp == LP_NONE));

    // R6: no restore into a mode whose enable is off
    a_r6_disabled_mode: assert property (@(posedge clk) disable iff (rst)
        (evt.resume && !lp_enabled(snap.prv, lp_en)) |=> (elp == LP_NONE));

endmodule

// File: rtl/dbg_resume_out.sv
module dbg_resume_out
    import dbgst_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter bit HAS_DT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  dbg_evt_t        evt,
    input  logic [XLEN-1:0] dpc,
    input  mode_snap_t      snap,
    output logic            resume_valid,
    output logic [XLEN-1:0] new_pc,
    output priv_e           new_priv,
    output logic            new_virt,
    output logic            clr_mprv,
    output logic            clr_mdt
);

    logic lowered;
    logic dt_hit;

    assign lowered = evt.resume && below_machine(snap.prv);

    generate
        if (HAS_DT) begin : g_dt
            assign dt_hit = lowered;
        end else begin : g_no_dt
            assign dt_hit = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            resume_valid <= 1'b0;
            new_pc       <= '0;
            new_priv     <= PRIV_M;
            new_virt     <= 1'b0;
            clr_mprv     <= 1'b0;
            clr_mdt      <= 1'b0;
        end else begin
            resume_valid <= evt.resume;
            clr_mprv     <= lowered;
            clr_mdt      <= dt_hit;
            if (evt.resume) begin
                new_pc   <= dpc;
                new_priv <= snap.prv;
                new_virt <= snap.v;
            end
        end
    end

    // R5: restore values follow the saved state
    a_r5_restore: assert property (@(posedge clk) disable iff (rst)
        evt.resume |=> (resume_valid && new_pc == $past(dpc)));

    // R7: memory-privilege-modify clear only on a return below machine mode
    a_r7_mprv_strobe: assert property (@(posedge clk) disable iff (rst)
        clr_mprv |-> (resume_valid && new_priv != PRIV_M));

    // R8: trap-lock clear only alongside a lowering resume
    a_r8_mdt_strobe: assert property (@(posedge clk) disable iff (rst)
        clr_mdt |-> (resume_valid && new_priv != PRIV_M));

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
    import dbgst_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 3,
    parameter bit HAS_LP  = 1'b1,
    parameter bit HAS_DT  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req,
    input  logic [CAUSE_W-1:0] halt_cause,
    input  logic               resume_req,
    input  logic               dret_valid,
    input  logic               in_progbuf,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [1:0]         cur_priv,
    input  logic               cur_virt,
    input  logic               elp_upd_en,
    input  logic               elp_upd_val,
    input  logic [2:0]         lp_en,
    input  logic               lpad_exec,
    output logic               halted,
    output logic [CAUSE_W-1:0] dcsr_cause,
    output logic [1:0]         dcsr_prv,
    output logic               dcsr_v,
    output logic               dcsr_pelp,
    output logic [XLEN-1:0]    dpc,
    output logic               elp,
    output logic               lpad_nop,
    output logic               resume_valid,
    output logic [XLEN-1:0]    new_pc,
    output logic [1:0]         new_priv,
    output logic               new_virt,
    output logic               clr_mprv,
    output logic               clr_mdt,
    output logic               illegal_dret
);

    dbg_evt_t   evt;
    mode_snap_t snap;
    priv_e      np;

    dbg_evt_decode u_decode (
        .clk          (clk),
        .rst          (rst),
        .halt_req     (halt_req),
        .resume_req   (resume_req),
        .dret_valid   (dret_valid),
        .in_progbuf   (in_progbuf),
        .evt          (evt),
        .halted       (halted),
        .illegal_dret (illegal_dret)
    );

    dbg_csr_hold #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .HAS_LP(HAS_LP)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .halt_cause (halt_cause),
        .cur_priv   (priv_e'(cur_priv)),
        .cur_virt   (cur_virt),
        .next_pc    (next_pc),
        .elp_now    (elp),
        .cause      (dcsr_cause),
        .snap       (snap),
        .dpc        (dpc)
    );

    dbg_elp_track #(.HAS_LP(HAS_LP)) u_elp (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .halted  (halted),
        .upd_en  (elp_upd_en),
        .upd_val (elp_upd_val),
        .snap    (snap),
        .lp_en   (lp_en),
        .elp     (elp)
    );

    dbg_resume_out #(.XLEN(XLEN), .HAS_DT(HAS_DT)) u_resume (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .dpc          (dpc),
        .snap         (snap),
        .resume_valid (resume_valid),
        .new_pc       (new_pc),
        .new_priv     (np),
        .new_virt     (new_virt),
        .clr_mprv     (clr_mprv),
        .clr_mdt      (clr_mdt)
    );

    assign new_priv  = np;
    assign dcsr_prv  = snap.prv;
    assign dcsr_v    = snap.v;
    assign dcsr_pelp = snap.pelp;
    assign lpad_nop  = halted && lpad_exec;

    // R2: a halt from running mode enters Debug Mode
    a_r2_enter: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !halted) |=> halted);

    // R3: landing-pad flag saved on entry and cleared live
    a_r3_save_elp: assert property (@(posedge clk) disable iff (rst)
        (halt_req && !halted) |=> (dcsr_pelp == (HAS_LP ? $past(elp) : 1'b0) && elp == 1'b0));

    // R4: landing-pad instruction is a no-op while halted
    a_r4_lpad_nop: assert property (@(posedge clk) disable iff (rst)
        (halted && lpad_exec) |-> lpad_nop);

endmodule

// File: tb/dbg_mode_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_mode_ctrl_tb_top;

    localparam int XLEN = 32;
    localparam int CW   = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_req = 0, resume_req = 0, dret_valid = 0, in_progbuf = 0;
    logic [CW-1:0] halt_cause = 0;
    logic [XLEN-1:0] next_pc = 0;
    logic [1:0] cur_priv = 0;
    logic cur_virt = 0, elp_upd_en = 0, elp_upd_val = 0, lpad_exec = 0;
    logic [2:0] lp_en = 0;

    logic halted, dcsr_v, dcsr_pelp, elp, lpad_nop, resume_valid, new_virt;
    logic clr_mprv, clr_mdt, illegal_dret;
    logic [CW-1:0] dcsr_cause;
    logic [1:0] dcsr_prv, new_priv;
    logic [XLEN-1:0] dpc, new_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dbg_mode_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) dut_i (
        .clk(clk), .rst(rst), .halt_req(halt_req), .halt_cause(halt_cause),
        .resume_req(resume_req), .dret_valid(dret_valid), .in_progbuf(in_progbuf),
        .next_pc(next_pc), .cur_priv(cur_priv), .cur_virt(cur_virt),
        .elp_upd_en(elp_upd_en), .elp_upd_val(elp_upd_val), .lp_en(lp_en),
        .lpad_exec(lpad_exec), .halted(halted), .dcsr_cause(dcsr_cause),
        .dcsr_prv(dcsr_prv), .dcsr_v(dcsr_v), .dcsr_pelp(dcsr_pelp), .dpc(dpc),
        .elp(elp), .lpad_nop(lpad_nop), .resume_valid(resume_valid),
        .new_pc(new_pc), .new_priv(new_priv), .new_virt(new_virt),
        .clr_mprv(clr_mprv), .clr_mdt(clr_mdt), .illegal_dret(illegal_dret)
    );

    // reference model state
    bit m_h, m_v, m_pelp, m_elp, m_rv, m_nv, m_cm, m_cd, m_ill;
    int m_cause, m_prv, m_npriv;
    longint m_dpc, m_npc;

    function automatic bit enabled_at(int p, logic [2:0] en);
        if (p == 0) return en[0];
        if (p == 1) return en[1];
        if (p == 3) return en[2];
        return 0;
    endfunction

    always @(posedge clk) begin
        bit hit_halt, hit_res;
        if (rst) begin
            m_h = 0; m_v = 0; m_pelp = 0; m_elp = 0; m_rv = 0; m_nv = 0;
            m_cm = 0; m_cd = 0; m_ill = 0; m_cause = 0; m_prv = 3;
            m_npriv = 3; m_dpc = 0; m_npc = 0;
        end else begin
            m_ill    = dret_valid && (!m_h || in_progbuf);
            hit_halt = halt_req && !m_h;
            hit_res  = m_h && !halt_req && (resume_req || (dret_valid && !in_progbuf));
            m_rv = hit_res;
            m_cm = hit_res && (m_prv != 3);
            m_cd = m_cm;
            if (hit_halt) begin
                m_cause = halt_cause; m_prv = cur_priv; m_v = cur_virt;
                m_dpc = next_pc; m_pelp = m_elp; m_elp = 0; m_h = 1;
            end else if (hit_res) begin
                m_npc = m_dpc; m_npriv = m_prv; m_nv = m_v;
                m_elp = enabled_at(m_prv, lp_en) ? m_pelp : 0;
                m_pelp = 0; m_h = 0;
            end else if (!m_h && elp_upd_en) begin
                m_elp = elp_upd_val;
            end
        end
    end

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R5 halted", halted, m_h);
        check("R2 cause", dcsr_cause, m_cause);
        check("R2 prv", dcsr_prv, m_prv);
        check("R2 virt", dcsr_v, m_v);
        check("R2 dpc", dpc, m_dpc);
        check("R3 pelp", dcsr_pelp, m_pelp);
        check("R6 elp", elp, m_elp);
        check("R4 lpad_nop", lpad_nop, m_h && lpad_exec);
        check("R5 resume_valid", resume_valid, m_rv);
        check("R5 new_pc", new_pc, m_npc);
        check("R5 new_priv", new_priv, m_npriv);
        check("R5 new_virt", new_virt, m_nv);
        check("R7 clr_mprv", clr_mprv, m_cm);
        check("R8 clr_mdt", clr_mdt, m_cd);
        check("R9 illegal", illegal_dret, m_ill);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        halt_req = 0; resume_req = 0; dret_valid = 0; in_progbuf = 0;
        elp_upd_en = 0; lpad_exec = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 halted", halted, 0);
        check("R1 prv", dcsr_prv, 3);
        check("R1 new_priv", new_priv, 3);
        check("R1 elp", elp, 0);
        check("R1 dpc", dpc, 0);
        check("R1 strobes", {resume_valid, clr_mprv, clr_mdt, illegal_dret}, 0);

        // R12: update while running
        elp_upd_en = 1; elp_upd_val = 1; tick(); idle();
        check("R12 elp set", elp, 1);

        // R12 / R3: halt from S, virt, with a same-cycle clearing update
        halt_req = 1; halt_cause = 3; cur_priv = 1; cur_virt = 1;
        next_pc = 32'h1000; elp_upd_en = 1; elp_upd_val = 0;
        tick(); idle();
        check("R12 pelp pre-update", dcsr_pelp, 1);
        check("R3 elp cleared", elp, 0);
        check("R2 dpc", dpc, 32'h1000);

        // R4: updates ignored while halted
        elp_upd_en = 1; elp_upd_val = 1; lpad_exec = 1; tick();
        check("R4 lpad_nop", lpad_nop, 1);
        idle();
        check("R4 elp quiet", elp, 0);

        // R10: second halt ignored
        halt_req = 1; halt_cause = 5; next_pc = 32'h2222; tick(); idle();
        check("R10 cause kept", dcsr_cause, 3);
        check("R10 dpc kept", dpc, 32'h1000);

        // R10: halt beats resume
        halt_req = 1; resume_req = 1; tick(); idle();
        check("R10 still halted", halted, 1);
        check("R10 no resume", resume_valid, 0);

        // R9: dret from program buffer
        dret_valid = 1; in_progbuf = 1; tick(); idle();
        check("R9 illegal", illegal_dret, 1);
        check("R9 still halted", halted, 1);

        // R5/R6/R7/R8: legal dret into S with enable on
        lp_en = 3'b010; dret_valid = 1; tick(); idle();
        check("R5 resumed", halted, 0);
        check("R5 new_pc", new_pc, 32'h1000);
        check("R6 elp restored", elp, 1);
        check("R6 pelp cleared", dcsr_pelp, 0);
        check("R7 mprv", clr_mprv, 1);
        check("R8 mdt", clr_mdt, 1);

        // R9 / R11: dret and resume while running
        dret_valid = 1; tick(); idle();
        check("R9 illegal running", illegal_dret, 1);
        resume_req = 1; tick(); idle();
        check("R11 no resume", resume_valid, 0);
        check("R11 no strobe", clr_mprv, 0);

        // R6/R7: halt from M with flag set, enable off for M
        halt_req = 1; cur_priv = 3; cur_virt = 0; next_pc = 32'h40; tick(); idle();
        lp_en = 3'b011; resume_req = 1; tick(); idle();
        check("R6 disabled mode", elp, 0);
        check("R7 no mprv in M", clr_mprv, 0);
        check("R8 no mdt in M", clr_mdt, 0);
        check("R5 new_priv M", new_priv, 3);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int pr;
            halt_req    = ($urandom % 7) == 0;
            resume_req  = ($urandom % 5) == 0;
            dret_valid  = ($urandom % 6) == 0;
            in_progbuf  = ($urandom % 3) == 0;
            halt_cause  = CW'($urandom);
            next_pc     = $urandom;
            pr          = $urandom % 4;
            cur_priv    = (pr == 2) ? 2'd3 : 2'(pr);
            cur_virt    = 1'($urandom);
            elp_upd_en  = ($urandom % 3) == 0;
            elp_upd_val = 1'($urandom);
            lp_en       = 3'($urandom);
            lpad_exec   = 1'($urandom);
            tick();
        end
        idle();
        tick();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule